// File: doc/BRIEF.md
# CPU program bank address translator

This block sits between a game console CPU and the program memory on a cartridge. It turns each 16-bit CPU address into a program ROM address, plus a ROM enable and a work-RAM enable. The CPU sees four 8 KiB windows. The window at $A000 always shows a bank chosen by software. The window at $E000 always shows the last bank of the ROM. The windows at $8000 and $C000 hold one software-chosen bank and the second-last bank, and a swap flag decides which window holds which.

An external decoder asserts one of three write strobes to update a register: the primary bank select, the secondary bank select, or the mode register. The write data comes from the CPU data bus. The translation is purely combinational from the address and the current register contents. A register write takes effect on the cycle after the strobe. The work-RAM enable covers only $6000-$6FFF. A 2 KiB RAM placed there therefore appears twice in that range, and the block passes out only the low 11 address bits.

Top module: `prg_xlate`

## Requirements
- R1: After reset, the primary select, the secondary select and the swap flag are all 0.
- R2: A read in $A000-$BFFF gives `rom_addr = {sel_b, cpu_addr[12:0]}`, where `sel_b` is the secondary select.
- R3: A read in $E000-$FFFF gives bank `NUM_BANKS-1` in `rom_addr[17:13]` and `cpu_addr[12:0]` in the low bits.
- R4: When the swap flag is 0, $8000-$9FFF gives the primary select bank and $C000-$DFFF gives bank `NUM_BANKS-2`.
- R5: When the swap flag is 1, $8000-$9FFF gives bank `NUM_BANKS-2` and $C000-$DFFF gives the primary select bank.
- R6: The swap flag is taken from bit 1 of the data written to the mode register. The other data bits have no effect.
- R7: A write to a bank select stores only data bits 4..0. Bits 7..5 are ignored.
- R8: `rom_en` is 1 exactly when `cpu_rw` is 1 (read) and `cpu_addr[15]` is 1. CPU writes never assert it.
- R9: `ram_en` is 1 exactly for accesses (read or write) with `cpu_addr[15:12] == 4'h6`, and `ram_addr = cpu_addr[10:0]`. The RAM therefore repeats every 2 KiB.
- R10: A register write takes effect on the clock edge at its strobe. When no strobe is high, the registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_data | input | 8 | CPU write data |
| wr_sel_a | input | 1 | Write strobe, primary bank select |
| wr_sel_b | input | 1 | Write strobe, secondary bank select |
| wr_mode | input | 1 | Write strobe, mode register |
| rom_addr | output | 18 | Program ROM byte address |
| rom_en | output | 1 | Program ROM read enable |
| ram_en | output | 1 | Work-RAM enable |
| ram_addr | output | 11 | Work-RAM byte address |

## Verification
A wrong swap flag shows as the $8000 and $C000 windows trading places. This appears on the very next read to either window after a mode write. A corrupted select register shows as a wrong upper field of `rom_addr`, but only when the CPU reads the window that uses that register. For that reason the bench reads every window after every write. A wrong fixed-bank computation is visible on any read of $E000 or of the fixed middle window, even with no register write.

// File: rtl/prg_xlate_pkg.sv
package prg_xlate_pkg;
  typedef enum logic [1:0] {
    WIN_LO  = 2'd0,
    WIN_MID = 2'd1,
    WIN_HI  = 2'd2,
    WIN_TOP = 2'd3
  } win_e;
endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs #(
  parameter int BANK_W = 5,
  parameter int DATA_W = 8,
  parameter int SWAP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we_a,
  input  logic              we_b,
  input  logic              we_mode,
  output logic [BANK_W-1:0] sel_a,
  output logic [BANK_W-1:0] sel_b,
  output logic              swap
);
  logic [BANK_W-1:0] sel_a_nx, sel_b_nx;
  logic              swap_nx;

  always_comb begin
    sel_a_nx = sel_a;
    sel_b_nx = sel_b;
    swap_nx  = swap;
    if (we_a)    sel_a_nx = wdata[BANK_W-1:0];
    if (we_b)    sel_b_nx = wdata[BANK_W-1:0];
    if (we_mode) swap_nx  = wdata[SWAP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a <= '0;
      sel_b <= '0;
      swap  <= 1'b0;
    end else begin
      sel_a <= sel_a_nx;
      sel_b <= sel_b_nx;
      swap  <= swap_nx;
    end
  end

  // R10: registers hold without a strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_a && !we_b && !we_mode |=> $stable(sel_a) && $stable(sel_b) && $stable(swap));
  // R6: swap follows data bit
  a_r6_swap: assert property (@(posedge clk) disable iff (!rst_n)
    we_mode |=> swap == $past(wdata[SWAP_BIT]));
  // R7: upper bits dropped
  a_r7_sel_a: assert property (@(posedge clk) disable iff (!rst_n)
    we_a |=> sel_a == $past(wdata[BANK_W-1:0]));
endmodule

// File: rtl/prg_addr_map.sv
module prg_addr_map
  import prg_xlate_pkg::*;
#(
  parameter int BANK_W = 5,
  parameter int NUM_BANKS = 32,
  parameter int PAGE_W = 13,
  parameter int RAM_AW = 11
) (
  input  logic [15:0]             cpu_addr,
  input  logic                    cpu_rw,
  input  logic [BANK_W-1:0]       sel_a,
  input  logic [BANK_W-1:0]       sel_b,
  input  logic                    swap,
  output logic [BANK_W+PAGE_W-1:0] rom_addr,
  output logic                    rom_en,
  output logic                    ram_en,
  output logic [RAM_AW-1:0]       ram_addr
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
  localparam logic [BANK_W-1:0] PENU_BANK = BANK_W'(NUM_BANKS - 2);

  win_e              win;
  logic [BANK_W-1:0] bank;

  always_comb begin
    win = win_e'(cpu_addr[14:13]);
    unique case (win)
      WIN_LO:  bank = swap ? PENU_BANK : sel_a;
      WIN_MID: bank = sel_b;
      WIN_HI:  bank = swap ? sel_a : PENU_BANK;
      default: bank = LAST_BANK;
    endcase
  end

  assign rom_addr = {bank, cpu_addr[PAGE_W-1:0]};
  assign rom_en   = cpu_rw & cpu_addr[15];
  assign ram_en   = (cpu_addr[15:12] == 4'h6);
  assign ram_addr = cpu_addr[RAM_AW-1:0];

  // R8 / R9: enables never overlap
  always_comb a_r8_r9_excl: assert (!(rom_en && ram_en));
endmodule

// File: rtl/prg_xlate.sv
module prg_xlate #(
  parameter int NUM_BANKS = 32,
  parameter int BANK_W = 5,
  parameter int PAGE_W = 13,
  parameter int RAM_AW = 11,
  localparam int ROM_AW = BANK_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_rw,
  input  logic [7:0]        cpu_data,
  input  logic              wr_sel_a,
  input  logic              wr_sel_b,
  input  logic              wr_mode,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_en,
  output logic              ram_en,
  output logic [RAM_AW-1:0] ram_addr
);
  logic [BANK_W-1:0] sel_a, sel_b;
  logic              swap;

  prg_bank_regs #(.BANK_W(BANK_W), .DATA_W(8), .SWAP_BIT(1)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(cpu_data),
    .we_a(wr_sel_a), .we_b(wr_sel_b), .we_mode(wr_mode),
    .sel_a(sel_a), .sel_b(sel_b), .swap(swap)
  );

  prg_addr_map #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .PAGE_W(PAGE_W), .RAM_AW(RAM_AW)) u_map (
    .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .sel_a(sel_a), .sel_b(sel_b), .swap(swap),
    .rom_addr(rom_addr), .rom_en(rom_en), .ram_en(ram_en), .ram_addr(ram_addr)
  );

  // R3: top window always last bank
  a_r3_last: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:13] == 3'b111 |-> rom_addr[ROM_AW-1:PAGE_W] == BANK_W'(NUM_BANKS - 1));
  // R8: writes never drive ROM
  a_r8_no_write_rom: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rw |-> !rom_en);
endmodule

// File: tb/prg_xlate_tb_top.sv
`timescale 1ns/1ps
module prg_xlate_tb_top;
  localparam int NB = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic cpu_rw = 1'b1;
  logic [7:0] cpu_data = '0;
  logic wr_sel_a = 0, wr_sel_b = 0, wr_mode = 0;
  logic [17:0] rom_addr;
  logic rom_en, ram_en;
  logic [10:0] ram_addr;
  int checks = 0, fails = 0;
  int m_a = 0, m_b = 0, m_swap = 0;

  always #2 clk = ~clk;

  prg_xlate dut_i (.*);

  function automatic int exp_bank(input logic [15:0] a);
    case (a[14:13])
      2'd0: return m_swap ? NB-2 : m_a;
      2'd1: return m_b;
      2'd2: return m_swap ? m_a : NB-2;
      default: return NB-1;
    endcase
  endfunction

  function automatic string req_of(input logic [15:0] a);
    case (a[14:13])
      2'd1: return "R2";
      2'd3: return "R3";
      default: return m_swap ? "R5" : "R4";
    endcase
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic rw);
    cpu_addr = a; cpu_rw = rw;
    #1;
    chk("R8", rom_en, (rw && a[15]) ? 1 : 0);
    chk("R9", ram_en, (a[15:12] == 4'h6) ? 1 : 0);
    if (a[15:12] == 4'h6) chk("R9", ram_addr, a[10:0]);
    if (a[15] && rw) chk(req_of(a), rom_addr, (exp_bank(a) << 13) | a[12:0]);
  endtask

  task automatic sweep();
    foreach (sweep_addrs[i]) access(sweep_addrs[i], 1'b1);
  endtask

  logic [15:0] sweep_addrs [8] = '{16'h8000, 16'h9FFF, 16'hA123, 16'hBFFF,
                                   16'hC000, 16'hD5A5, 16'hE000, 16'hFFFF};

  task automatic wr(input int which, input logic [7:0] d);
    @(negedge clk);
    cpu_data = d; cpu_rw = 1'b0;
    wr_sel_a = (which == 0); wr_sel_b = (which == 1); wr_mode = (which == 2);
    @(negedge clk);
    wr_sel_a = 0; wr_sel_b = 0; wr_mode = 0; cpu_rw = 1'b1;
    if (which == 0) m_a = d[4:0];
    if (which == 1) m_b = d[4:0];
    if (which == 2) m_swap = d[1];
  endtask

  initial begin
    #4000;
    fails++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    sweep();
    // R7: upper bits ignored
    wr(0, 8'hE9); sweep();
    wr(1, 8'hB3); sweep();
    // R6: bit 1 swap, other bits ignored
    wr(2, 8'hFD); sweep();
    wr(2, 8'h02); sweep();
    wr(0, 8'h1F); sweep();
    wr(1, 8'h00); sweep();
    wr(2, 8'h01); sweep();
    // R10: hold with no strobe but activity on data
    @(negedge clk); cpu_data = 8'hFF; repeat (3) @(negedge clk); sweep();
    // R8 write accesses / R9 RAM mirror
    access(16'h8000, 1'b0); access(16'hE123, 1'b0);
    access(16'h6000, 1'b1); access(16'h6812, 1'b0); access(16'h6FFF, 1'b1);
    access(16'h7000, 1'b1); access(16'h5FFF, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule